// File: doc/BRIEF.md
# Three-Digit Decimal Accumulator Processor

This block is a small teaching processor whose words hold decimal values from 0 to 999, stored internally as 10-bit binary numbers. It owns an array of 100 words that serves as both program and data store, an accumulator, a program counter and a negative flag. Each instruction word is split by its hundreds digit into an operation and by its two low digits into a word address. It then runs in two phases, a fetch and an execute.

Two handshaked ports connect the processor to a host. An input port delivers a value into the accumulator, and an output port presents the accumulator. A halted status output and an illegal-instruction output report when execution has stopped. The memory array has no reset. A host fills it through a dedicated write port while the processor is held in reset, and its contents survive later resets.

Top module: `dec_acc_cpu`

## Requirements
- R1: While rst_ni is low, the accumulator, program counter and negative flag are cleared, and halted_o, illegal_o, in_ready_o and out_valid_o are low. The load port writes memory only while rst_ni is low. Memory contents are not changed by reset.
- R2: A fetched word w has operation digit w/100 and address w%100. After every fetch the program counter advances by one, wrapping from 99 to 0, unless a taken branch loads it.
- R3: Word 1xx sets the accumulator to (accumulator + mem[xx]) mod 1000 and clears the negative flag.
- R4: Word 2xx subtracts mem[xx] from the accumulator. If mem[xx] exceeds the accumulator, the negative flag is set and the accumulator value is unspecified. Otherwise the difference is exact and the flag is left as it was.
- R5: Word 3xx writes the accumulator to mem[xx] and leaves the accumulator unchanged. Word 5xx copies mem[xx] into the accumulator, leaves mem[xx] unchanged and clears the negative flag.
- R6: Word 6xx always jumps to xx. Word 7xx jumps to xx only when the accumulator is 0. Word 8xx jumps to xx only when the negative flag is clear.
- R7: Word 901 raises in_ready_o and holds it until in_valid_i is seen high. It then loads in_data_i into the accumulator (values of 1000 and above reduced by 1000) and clears the negative flag.
- R8: Word 902 raises out_valid_o with out_data_o equal to the accumulator. Both are held unchanged until out_ready_i is high, and the accumulator is not modified.
- R9: Any word below 100 halts the processor. halted_o then stays high and illegal_o stays low until reset.
- R10: Words 4xx, 9xx other than 901 and 902, and values of 1000 or more halt the processor with both halted_o and illegal_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; memory loading window |
| load_we_i | input | 1 | Memory preload write enable (honoured in reset only) |
| load_addr_i | input | 7 | Memory preload address |
| load_data_i | input | 10 | Memory preload data |
| in_data_i | input | 10 | Input port value |
| in_valid_i | input | 1 | Input port value available |
| in_ready_o | output | 1 | Processor waiting on input |
| out_data_o | output | 10 | Output port value (accumulator) |
| out_valid_o | output | 1 | Output value presented |
| out_ready_i | input | 1 | Host accepts output value |
| halted_o | output | 1 | Execution stopped |
| illegal_o | output | 1 | Stopped on an unused encoding |

## Verification
The bench builds the processor with its default sizes: 10-bit words, 100 memory words and 7-bit addresses. At these sizes the decimal limits are reachable. A sum of 999 and 999 wraps, a program placed at word 99 wraps to word 0, and every hundreds digit from 0 to 9 can be preloaded. A table-driven arithmetic program then runs through carry, borrow and zero outcomes. Directed programs hold the handshakes stalled, exercise the sticky negative flag, and drive the halt and illegal encodings.

// File: rtl/dec_acc_pkg.sv
package dec_acc_pkg;
  localparam int WORD_W    = 10;
  localparam int MEM_WORDS = 100;
  localparam int ADDR_W    = $clog2(MEM_WORDS);
  localparam int WORD_MOD  = 1000;
  localparam int DIGIT_DIV = 100;

  typedef enum logic [3:0] {
    OP_HALT, OP_ADD, OP_SUB, OP_STA, OP_LDA,
    OP_BRA, OP_BRZ, OP_BRP, OP_IN, OP_OUT, OP_ILL
  } op_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_EXEC, ST_IN, ST_OUT, ST_HALT
  } state_e;
endpackage

// File: rtl/dec_acc_mem.sv
module dec_acc_mem #(
  parameter int DEPTH  = 100,
  parameter int WORD_W = 10,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && (int'(waddr_i) < DEPTH)) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = (int'(raddr_i) < DEPTH) ? mem_q[raddr_i] : '0;
endmodule

// File: rtl/dec_acc_decode.sv
module dec_acc_decode
  import dec_acc_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o
);
  int digit, low;

  always_comb begin
    digit  = int'(word_i) / DIGIT_DIV;
    low    = int'(word_i) % DIGIT_DIV;
    addr_o = ADDR_W'(low);
    case (digit)
      0:       op_o = OP_HALT;
      1:       op_o = OP_ADD;
      2:       op_o = OP_SUB;
      3:       op_o = OP_STA;
      5:       op_o = OP_LDA;
      6:       op_o = OP_BRA;
      7:       op_o = OP_BRZ;
      8:       op_o = OP_BRP;
      9: begin
        if (low == 1)      op_o = OP_IN;
        else if (low == 2) op_o = OP_OUT;
        else               op_o = OP_ILL;
      end
      default: op_o = OP_ILL;
    endcase
  end
endmodule

// File: rtl/dec_acc_alu.sv
module dec_acc_alu
  import dec_acc_pkg::*;
(
  input  logic [WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0] opnd_i,
  output logic [WORD_W-1:0] sum_o,
  output logic [WORD_W-1:0] diff_o,
  output logic              borrow_o
);
  localparam logic [WORD_W:0] MOD_W = (WORD_W+1)'(WORD_MOD);
  logic [WORD_W:0] sum_raw, diff_raw;

  always_comb begin
    sum_raw  = {1'b0, acc_i} + {1'b0, opnd_i};
    borrow_o = opnd_i > acc_i;
    // wrapped difference keeps the accumulator in range when negative
    diff_raw = borrow_o ? ({1'b0, acc_i} + MOD_W - {1'b0, opnd_i})
                        : ({1'b0, acc_i} - {1'b0, opnd_i});
    sum_o    = (sum_raw >= MOD_W) ? WORD_W'(sum_raw - MOD_W) : WORD_W'(sum_raw);
    diff_o   = (diff_raw >= MOD_W) ? WORD_W'(diff_raw - MOD_W) : WORD_W'(diff_raw);
  end
endmodule

// File: rtl/dec_acc_cpu.sv
module dec_acc_cpu
  import dec_acc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_we_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [WORD_W-1:0] out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              halted_o,
  output logic              illegal_o
);
  localparam logic [WORD_W-1:0] MOD_W  = WORD_W'(WORD_MOD);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(MEM_WORDS - 1);

  state_e            state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [WORD_W-1:0] acc_q, ir_q;
  logic              neg_q, ill_q;

  op_e               op;
  logic [ADDR_W-1:0] op_addr, rd_addr, wr_addr;
  logic [WORD_W-1:0] rd_data, wr_data, sum, diff;
  logic              borrow, cpu_we, mem_we;

  dec_acc_decode u_decode (.word_i(ir_q), .op_o(op), .addr_o(op_addr));

  dec_acc_alu u_alu (
    .acc_i(acc_q), .opnd_i(rd_data), .sum_o(sum), .diff_o(diff), .borrow_o(borrow)
  );

  assign cpu_we  = (state_q == ST_EXEC) && (op == OP_STA);
  assign mem_we  = (!rst_ni && load_we_i) || cpu_we;
  assign wr_addr = rst_ni ? op_addr : load_addr_i;
  assign wr_data = rst_ni ? acc_q : load_data_i;
  assign rd_addr = (state_q == ST_FETCH) ? pc_q : op_addr;

  dec_acc_mem #(.DEPTH(MEM_WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i(clk_i), .we_i(mem_we), .waddr_i(wr_addr), .wdata_i(wr_data),
    .raddr_i(rd_addr), .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      acc_q   <= '0;
      ir_q    <= '0;
      neg_q   <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_FETCH: begin
          ir_q    <= rd_data;
          pc_q    <= (pc_q == LAST_A) ? '0 : pc_q + 1'b1;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          state_q <= ST_FETCH;
          case (op)
            OP_HALT: state_q <= ST_HALT;
            OP_ILL: begin
              state_q <= ST_HALT;
              ill_q   <= 1'b1;
            end
            OP_ADD: begin
              acc_q <= sum;
              neg_q <= 1'b0;
            end
            OP_SUB: begin
              acc_q <= diff;
              if (borrow) neg_q <= 1'b1;
            end
            OP_LDA: begin
              acc_q <= rd_data;
              neg_q <= 1'b0;
            end
            OP_BRA:  pc_q <= op_addr;
            OP_BRZ:  if (acc_q == '0) pc_q <= op_addr;
            OP_BRP:  if (!neg_q) pc_q <= op_addr;
            OP_IN:   state_q <= ST_IN;
            OP_OUT:  state_q <= ST_OUT;
            default: ;
          endcase
        end
        ST_IN: begin
          if (in_valid_i) begin
            acc_q   <= (in_data_i >= MOD_W) ? in_data_i - MOD_W : in_data_i;
            neg_q   <= 1'b0;
            state_q <= ST_FETCH;
          end
        end
        ST_OUT:  if (out_ready_i) state_q <= ST_FETCH;
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign in_ready_o  = state_q == ST_IN;
  assign out_valid_o = state_q == ST_OUT;
  assign out_data_o  = acc_q;
  assign halted_o    = state_q == ST_HALT;
  assign illegal_o   = ill_q;
endmodule

// File: rtl/dec_acc_cpu_chk.sv
module dec_acc_cpu_chk
  import dec_acc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [WORD_W-1:0] out_data_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic              halted_o,
  input logic              illegal_o,
  input logic [ADDR_W-1:0] pc_q,
  input logic [WORD_W-1:0] acc_q
);
  // R2
  a_r2_pc_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pc_q) < MEM_WORDS);
  // R3
  a_r3_acc_decimal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(acc_q) < WORD_MOD);
  a_r7_in_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !in_valid_i) |=> in_ready_o);
  a_r8_out_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  a_r9_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(illegal_o)));
  a_r10_illegal_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> halted_o);
  a_r8_one_wait_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({in_ready_o, out_valid_o, halted_o}));
endmodule

bind dec_acc_cpu dec_acc_cpu_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .halted_o(halted_o), .illegal_o(illegal_o), .pc_q(pc_q), .acc_q(acc_q)
);

// File: tb/dec_acc_cpu_bench.sv
module dec_acc_cpu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_we = 1'b0;
  logic [6:0] load_addr = '0;
  logic [9:0] load_data = '0;
  logic [9:0] in_data;
  logic       in_valid, in_ready, out_valid, halted, illegal;
  logic [9:0] out_data;
  logic       out_ready = 1'b1;

  int n_chk = 0, n_fail = 0;
  logic       clr = 1'b1;
  logic [9:0] in_q [8];
  int in_cnt = 0, in_idx, out_cnt;
  logic [9:0] out_buf [8];

  always #10 clk = ~clk;

  assign in_valid = in_idx < in_cnt;
  assign in_data  = in_q[in_idx[2:0]];

  always @(posedge clk) begin
    if (clr) begin
      in_idx  <= 0;
      out_cnt <= 0;
    end else begin
      if (in_ready && in_valid) in_idx <= in_idx + 1;
      if (out_valid && out_ready) begin
        if (out_cnt < 8) out_buf[out_cnt[2:0]] <= out_data;
        out_cnt <= out_cnt + 1;
      end
    end
  end

  dec_acc_cpu u_dec_acc_cpu (
    .clk_i(clk), .rst_ni(rst_n), .load_we_i(load_we), .load_addr_i(load_addr),
    .load_data_i(load_data), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .out_data_o(out_data), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .halted_o(halted), .illegal_o(illegal)
  );

  // a, b, a+b mod 1000, a-b or 999 when negative, equal flag
  localparam int VEC [6][5] = '{
    '{123, 456, 579, 999, 0}, '{700, 500, 200, 200, 0}, '{999, 999, 998, 0, 1},
    '{5, 5, 10, 0, 1},        '{0, 1, 1, 999, 0},       '{450, 449, 899, 1, 0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    clr   = 1'b1;
    @(negedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk);
    clr   = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic poke(input int a, input int d);
    load_we   = 1'b1;
    load_addr = 7'(a);
    load_data = 10'(d);
    @(negedge clk);
    load_we   = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 100; i++) poke(i, 0);
  endtask

  task automatic wait_halt();
    for (int i = 0; i < 400 && !halted; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    hold_reset();
    // R1 reset state
    chk("R1 halted", int'(halted), 0);
    chk("R1 illegal", int'(illegal), 0);
    chk("R1 in_ready", int'(in_ready), 0);
    chk("R1 out_valid", int'(out_valid), 0);

    clear_mem();
    poke(0, 901); poke(1, 390); poke(2, 901); poke(3, 391);
    poke(4, 590); poke(5, 191); poke(6, 902); poke(7, 590);
    poke(8, 291); poke(9, 812); poke(10, 592); poke(11, 612);
    poke(12, 902); poke(13, 715); poke(14, 0); poke(15, 593);
    poke(16, 902); poke(17, 0); poke(92, 999); poke(93, 777);

    for (int v = 0; v < 6; v++) begin
      hold_reset();
      in_q[0] = 10'(VEC[v][0]);
      in_q[1] = 10'(VEC[v][1]);
      in_cnt  = 2;
      release_reset();
      wait_halt();
      chk("R9 halted", int'(halted), 1);
      chk("R3 sum wraps", int'(out_buf[0]), VEC[v][2]);
      chk("R4 R6 diff or negative path", int'(out_buf[1]), VEC[v][3]);
      chk("R6 zero branch count", out_cnt, VEC[v][4] ? 3 : 2);
      if (VEC[v][4] != 0) chk("R5 load of stored word", int'(out_buf[2]), 777);
    end

    // R7 input stall
    hold_reset();
    in_cnt = 0;
    release_reset();
    repeat (10) @(negedge clk);
    chk("R7 in_ready held", int'(in_ready), 1);
    chk("R7 no output while stalled", out_cnt, 0);
    in_q[0] = 10'd1020; in_q[1] = 10'd20;
    in_cnt  = 2;
    wait_halt();
    chk("R7 input reduced mod 1000", int'(out_buf[0]), 40);
    chk("R7 equal inputs zero path", out_cnt, 3);

    // R2 R8 wrap and output stall
    hold_reset();
    clear_mem();
    poke(0, 902); poke(1, 699); poke(99, 594); poke(94, 123);
    out_ready = 1'b0;
    release_reset();
    repeat (6) @(negedge clk);
    chk("R8 out_valid", int'(out_valid), 1);
    chk("R8 out data is reset acc", int'(out_data), 0);
    repeat (5) @(negedge clk);
    chk("R8 out held", int'(out_valid), 1);
    chk("R8 no transfer", out_cnt, 0);
    out_ready = 1'b1;
    for (int i = 0; i < 50 && out_cnt < 2; i++) @(negedge clk);
    chk("R2 pc wraps 99 to 0", int'(out_buf[1]), 123);

    // R4 sticky negative flag
    hold_reset();
    clear_mem();
    poke(0, 596); poke(1, 297); poke(2, 298); poke(3, 806);
    poke(4, 0); poke(6, 902); poke(96, 5); poke(97, 7); poke(98, 0);
    release_reset();
    wait_halt();
    chk("R4 negative flag sticky", out_cnt, 0);
    // R3 add clears flag
    hold_reset();
    poke(2, 198);
    release_reset();
    wait_halt();
    chk("R3 add clears negative", out_cnt, 1);

    // R10 illegal encodings
    hold_reset();
    poke(0, 412);
    release_reset();
    wait_halt();
    chk("R10 4xx illegal", int'(illegal), 1);
    hold_reset();
    poke(0, 903);
    release_reset();
    wait_halt();
    repeat (4) @(negedge clk);
    chk("R10 903 illegal", int'(illegal), 1);
    chk("R10 halted", int'(halted), 1);

    // R9 plain halt
    hold_reset();
    poke(0, 50);
    release_reset();
    wait_halt();
    chk("R9 halt not illegal", int'(illegal), 0);
    chk("R9 halted", int'(halted), 1);

    // R1 load port ignored out of reset
    poke(0, 902);
    hold_reset();
    release_reset();
    wait_halt();
    chk("R1 run-time load ignored", out_cnt, 0);
    chk("R1 still halts", int'(halted), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule